// File: doc/BRIEF.md
# UART Transmitter with Holding and Shift Registers

This block is the transmit side of a serial port. A host offers one character at a time through a single-cycle write strobe. The character lands in a holding register, and a ready flag tells the host when that register may take another one. A separate shift register drains the holding register and sends each character on a serial line as an 8N1 frame. The baud rate is set by an external single-cycle tick pulse. With two stages, the host can queue the next character while the current frame is still going out, and frames leave back to back.

The ready flag is the only handshake. A host write clears it. It is set again only when the shift register takes the held character. Writes that arrive while the flag is clear, or while the transmitter is disabled, are dropped without a trace. An empty output tells the host that both stages are idle.

Top module: `uart_tx_dbuf`

## Requirements
- R1: The serial line `txd_o` is high whenever no frame is in progress. A frame is one low start bit, then the data bits least significant first, then one high stop bit.
- R2: `txd_o` changes only on a clock edge at which `baud_tick_i` is high, so each frame bit lasts exactly one tick interval.
- R3: After reset, `tx_ready_o` is 1, `tx_empty_o` is 1 and `txd_o` is 1.
- R4: A write is accepted when `wr_valid_i`, `tx_ready_o` and `tx_en_i` are all 1 at a clock edge. The accepted byte is stored, and `tx_ready_o` is 0 from that edge on.
- R5: A write made while `tx_ready_o` is 0 is ignored. The held byte is unchanged, and the ignored byte never appears on `txd_o`.
- R6: A write made while `tx_en_i` is 0 is ignored. `tx_ready_o` stays 1, and no frame is produced.
- R7: The shift register takes the held byte on a tick edge at which it is idle or is finishing a stop bit. `tx_ready_o` returns to 1 at that same edge, and at no other time.
- R8: A byte that is held when a stop bit ends starts its start bit right after that stop bit, with no idle bit time in between.
- R9: `tx_empty_o` is 1 exactly when `tx_ready_o` is 1 and no frame is being sent.
- R10: Taking `tx_en_i` low does not abort a frame in progress or discard a byte already held. Both are still sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Transmitter enable; gates write acceptance |
| baud_tick_i | input | 1 | One-cycle pulse per bit time |
| wr_valid_i | input | 1 | Host write strobe |
| wr_data_i | input | DATA_W | Character to send |
| tx_ready_o | output | 1 | Holding register free to accept a write |
| tx_empty_o | output | 1 | Holding and shift registers both idle |
| txd_o | output | 1 | Serial output line |

## Verification
The hardest condition to reach is a byte that sits in the holding register while a stop bit ends. That is the only case that exercises the zero-gap chaining path. To reach it, the stimulus waits for `tx_ready_o` to rise after the first load and then writes a second byte at once, which keeps the second byte waiting for most of a frame. The bench also measures the idle bit times between the two decoded frames and expects zero. Random write attempts with random spacing and occasional disabling then produce writes against a clear flag, writes with the transmitter off, and enable drops in the middle of a frame. A serial decoder in the bench checks every resulting frame against the queue of bytes it predicted would be accepted.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam logic LINE_IDLE = 1'b1;
  localparam logic START_LVL = 1'b0;
  localparam logic STOP_LVL  = 1'b1;
endpackage

// File: rtl/uart_tx_rst_sync.sv
module uart_tx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_en_i,
  input  logic              take_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] data_o
);
  logic              ready_q, ready_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              accept;

  assign accept = wr_valid_i & ready_q & tx_en_i;

  always_comb begin
    ready_d = ready_q;
    hold_d  = hold_q;
    if (accept) begin
      hold_d  = wr_data_i;
      ready_d = 1'b0;
    end else if (take_i) begin
      ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      hold_q  <= '0;
    end else begin
      ready_q <= ready_d;
      hold_q  <= hold_d;
    end
  end

  assign ready_o = ready_q;
  assign data_o  = hold_q;
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              held_valid_i,
  input  logic [DATA_W-1:0] held_data_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               busy_q, busy_d;
  logic               last_bit;
  logic               take;

  assign last_bit = busy_q && (cnt_q == LAST_IDX);
  assign take     = tick_i && held_valid_i && (!busy_q || last_bit);

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    if (take) begin
      shreg_d = {STOP_LVL, held_data_i, START_LVL};
      cnt_d   = '0;
      busy_d  = 1'b1;
    end else if (tick_i && busy_q) begin
      if (last_bit) begin
        shreg_d = {FRAME_W{LINE_IDLE}};
        cnt_d   = '0;
        busy_d  = 1'b0;
      end else begin
        shreg_d = {LINE_IDLE, shreg_q[FRAME_W-1:1]};
        cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= {FRAME_W{LINE_IDLE}};
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
    end
  end

  assign take_o = take;
  assign busy_o = busy_q;
  assign txd_o  = shreg_q[0];
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              baud_tick_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tx_ready_o,
  output logic              tx_empty_o,
  output logic              txd_o
);
  logic              rst_sync_n;
  logic              ready;
  logic              take;
  logic              busy;
  logic [DATA_W-1:0] held;

  uart_tx_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .tx_en_i    (tx_en_i),
    .take_i     (take),
    .ready_o    (ready),
    .data_o     (held)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .tick_i       (baud_tick_i),
    .held_valid_i (~ready),
    .held_data_i  (held),
    .take_o       (take),
    .busy_o       (busy),
    .txd_o        (txd_o)
  );

  assign tx_ready_o = ready;
  assign tx_empty_o = ready & ~busy;
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
  input logic clk_i,
  input logic rst_sync_i,
  input logic tx_en_i,
  input logic baud_tick_i,
  input logic wr_valid_i,
  input logic tx_ready_o,
  input logic tx_empty_o,
  input logic txd_o
);
  a_r1_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_sync_i)
    tx_empty_o |-> txd_o);

  a_r2_line_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_sync_i)
    !baud_tick_i |=> $stable(txd_o));

  a_r4_accept_clears_ready: assert property (@(posedge clk_i) disable iff (!rst_sync_i)
    (wr_valid_i && tx_ready_o && tx_en_i) |=> !tx_ready_o);

  a_r6_disabled_keeps_ready: assert property (@(posedge clk_i) disable iff (!rst_sync_i)
    (tx_ready_o && !tx_en_i) |=> tx_ready_o);

  a_r5_clear_stays_without_tick: assert property (@(posedge clk_i) disable iff (!rst_sync_i)
    (!tx_ready_o && !baud_tick_i) |=> !tx_ready_o);

  a_r7_ready_rises_on_tick: assert property (@(posedge clk_i) disable iff (!rst_sync_i)
    $rose(tx_ready_o) |-> $past(baud_tick_i));

  a_r9_empty_implies_ready: assert property (@(posedge clk_i) disable iff (!rst_sync_i)
    tx_empty_o |-> tx_ready_o);
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
  .clk_i       (clk_i),
  .rst_sync_i  (rst_sync_n),
  .tx_en_i     (tx_en_i),
  .baud_tick_i (baud_tick_i),
  .wr_valid_i  (wr_valid_i),
  .tx_ready_o  (tx_ready_o),
  .tx_empty_o  (tx_empty_o),
  .txd_o       (txd_o)
);

// File: tb/tb_uart_tx_dbuf.sv
module tb_uart_tx_dbuf;
  localparam int DATA_W   = 8;
  localparam int BAUD_DIV = 4;

  logic              clk;
  logic              rst_n;
  logic              tx_en;
  logic              baud_tick;
  logic              wr_valid;
  logic [DATA_W-1:0] wr_data;
  logic              tx_ready, tx_empty, txd;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [DATA_W-1:0] exp_q[$];
  logic tick_seen;
  int   dec_state = 0;
  int   dec_idx   = 0;
  logic [DATA_W-1:0] dec_byte;
  int   idle_cnt  = 0;
  int   last_gap  = 0;
  int   frames    = 0;
  int   stab_err  = 0;
  logic prev_txd  = 1'b1;
  int   tick_cnt  = 0;

  uart_tx_dbuf #(.DATA_W(DATA_W)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tx_en_i     (tx_en),
    .baud_tick_i (baud_tick),
    .wr_valid_i  (wr_valid),
    .wr_data_i   (wr_data),
    .tx_ready_o  (tx_ready),
    .tx_empty_o  (tx_empty),
    .txd_o       (txd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) tick_seen <= baud_tick;

  function automatic logic is_stop_ok(input logic b);
    return b == 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick generation plus serial decoding, all at the falling edge
  always @(negedge clk) begin
    logic t;
    if (!rst_n) begin
      baud_tick <= 1'b0;
      tick_cnt  = 0;
      prev_txd  = txd;
    end else begin
      if (!tick_seen && txd !== prev_txd) stab_err++;
      prev_txd = txd;
      t = (tick_cnt == BAUD_DIV - 1);
      tick_cnt = t ? 0 : tick_cnt + 1;
      if (t) begin
        case (dec_state)
          0: if (txd == 1'b0) begin
               dec_state = 1; dec_idx = 0; last_gap = idle_cnt; idle_cnt = 0;
             end else idle_cnt++;
          1: begin
               dec_byte[dec_idx] = txd;
               dec_idx++;
               if (dec_idx == DATA_W) dec_state = 2;
             end
          default: begin
               check(is_stop_ok(txd), "R1 stop bit", int'(txd), 1);
               if (exp_q.size() == 0)
                 check(1'b0, "R5/R6 unexpected frame", int'(dec_byte), -1);
               else begin
                 logic [DATA_W-1:0] e;
                 e = exp_q.pop_front();
                 check(dec_byte == e, "R1 frame data", int'(dec_byte), int'(e));
               end
               frames++;
               dec_state = 0;
             end
        endcase
      end
      baud_tick <= t;
    end
  end

  task automatic do_write(input logic [DATA_W-1:0] d, input logic en);
    logic acc, rdy0;
    @(negedge clk);
    tx_en    = en;
    wr_valid = 1'b1;
    wr_data  = d;
    rdy0     = tx_ready;
    acc      = tx_ready && en;
    @(negedge clk);
    wr_valid = 1'b0;
    if (acc) begin
      exp_q.push_back(d);
      check(tx_ready == 1'b0, "R4 ready clears", int'(tx_ready), 0);
    end else if (rdy0 && !en) begin
      check(tx_ready == 1'b1, "R6 ready kept", int'(tx_ready), 1);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(tx_empty && dec_state == 0 && exp_q.size() == 0) && n < 4000);
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!tx_ready && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int f0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tx_en = 1'b1; wr_valid = 1'b0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset state
    check(tx_ready == 1'b1, "R3 ready after reset", int'(tx_ready), 1);
    check(tx_empty == 1'b1, "R3 empty after reset", int'(tx_empty), 1);
    check(txd == 1'b1,      "R3 line after reset", int'(txd), 1);

    // R6 disabled write ignored
    f0 = frames;
    do_write(8'hA5, 1'b0);
    repeat (BAUD_DIV * 12) @(negedge clk);
    check(frames == f0, "R6 no frame when disabled", frames, f0);
    check(tx_empty == 1'b1, "R6 still empty", int'(tx_empty), 1);

    // R7 ready rises on a tick edge; R9 empty drops during frame
    do_write(8'h3C, 1'b1);
    check(tx_empty == 1'b0, "R9 empty low when held", int'(tx_empty), 0);
    wait_ready();
    check(tick_seen == 1'b1, "R7 ready rose on tick edge", int'(tick_seen), 1);
    check(tx_empty == 1'b0, "R9 empty low while sending", int'(tx_empty), 0);

    // R8 back-to-back, R5 write while ready clear ignored
    do_write(8'hC3, 1'b1);
    do_write(8'hFF, 1'b1);          // ready is clear: must be dropped (R5)
    wait_idle();
    check(last_gap == 0, "R8 no gap between frames", last_gap, 0);
    check(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
    check(tx_empty == 1'b1 && txd == 1'b1, "R1 R9 idle after frames",
          int'({tx_empty, txd}), 3);

    // R10 disable does not abort frame or held byte
    do_write(8'h81, 1'b1);
    wait_ready();
    do_write(8'h7E, 1'b1);
    @(negedge clk);
    tx_en = 1'b0;
    f0 = frames;
    wait_idle();
    check(frames == f0 + 2, "R10 both bytes sent while disabled", frames, f0 + 2);
    tx_en = 1'b1;

    // random stimulus
    for (int i = 0; i < 80; i++) begin
      do_write(DATA_W'($urandom), ($urandom % 8) != 0);
      repeat ($urandom % 60) @(negedge clk);
    end
    wait_idle();
    check(exp_q.size() == 0, "R1 all accepted bytes decoded", exp_q.size(), 0);
    check(tx_empty == 1'b1, "R9 empty at end", int'(tx_empty), 1);
    check(stab_err == 0, "R2 line stable between ticks", stab_err, 0);
    finish_run();
  end
endmodule